// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed instruction into the single 32-bit base-ISA instruction that does the same work. It sits between instruction fetch and the main decoder, so everything after it only ever sees full-width encodings. Each halfword maps onto exactly one wide instruction. The block never produces a sequence of instructions.

The expansion does three things. It widens 3-bit register fields onto x8..x15. It adds the implied stack pointer, return address or zero register. It rebuilds the scrambled, scaled immediates into the layouts the wide formats use. A word whose low two bits are `11` is already wide, so it passes through unchanged. Any halfword outside the supported subset raises an illegal flag. The input is taken as a 32-bit word so that the pass-through case keeps its upper half. Results are registered, giving one cycle of latency.

Top module: `rvc_expander`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous cycle, and all outputs are zero after reset. On a valid input, `out_instr` and `out_illegal` show its result on the next cycle.
- R2: If `in_instr[1:0]` is `11`, then `out_instr` equals `in_instr` and `out_illegal` is 0.
- R3: A 3-bit register field `f` (bits 9:7 or 4:2) selects register x(8+f).
- R4: Quadrant `00`, funct3 `010` expands to lw. Funct3 `110` expands to sw. The zero-extended word offset is {b5, b12:10, b6, 00}.
- R5: Quadrant `10`, funct3 `010` expands to lw rd,off(x2) with off = {b3:2, b12, b6:4, 00}. Funct3 `110` expands to sw rs2,off(x2) with off = {b8:7, b12:9, 00}. Here rd is b11:7 and rs2 is b6:2.
- R6: Quadrant `01`, funct3 `000` expands to addi rd,rd,imm. Funct3 `010` expands to addi rd,x0,imm. In both, imm is {b12, b6:2} sign-extended.
- R7: Quadrant `01`, funct3 `011` with rd = 2 expands to addi x2,x2,imm. Here imm = {b12, b4:3, b5, b2, b6, 0000}, sign-extended. A zero imm is illegal.
- R8: Quadrant `01`, funct3 `001` expands to jal x1. Funct3 `101` expands to jal x0. The offset bits [11|4|9:8|10|6|7|3:1|5] come from b12..b2, are sign-extended, and bit 0 is 0.
- R9: Quadrant `01`, funct3 `110` or `111` expands to beq or bne rs1',x0. The offset bits [8|4:3] come from b12:10 and [7:6|2:1|5] from b6:2. The offset is sign-extended and bit 0 is 0.
- R10: Quadrant `10`, b15:12 = `1000` expands to add rd,x0,rs2. If rd or rs2 is 0, the input is illegal. b15:12 = `1001` expands to add rd,rd,rs2. If rs2 is 0, the input is illegal.
- R11: The following are illegal: the all-zero halfword, every other funct3 or form, and quadrant `01` funct3 `011` with rd ≠ 2. When the input is illegal, `out_instr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_instr | input | 32 | Fetched word; low half holds a compressed form |
| out_valid | output | 1 | Registered valid |
| out_instr | output | 32 | Expanded 32-bit instruction |
| out_illegal | output | 1 | Input is not a supported encoding |

## Verification
The assertions take `in_instr` as meaningful only in cycles where `in_valid` is high. Their implications all start from a valid input, so whatever the bench leaves on the bus while idle does not matter. The random stimulus picks register numbers and immediates over their full legal ranges for each form. It leaves out the zero-immediate and zero-register values that would turn a legal form into an illegal one. Those values are instead applied as directed corner cases, each with the illegal result expected.

// File: rtl/rvc_expander.sv
module rvc_expander (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  output logic        out_valid,
  output logic [31:0] out_instr,
  output logic        out_illegal
);
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_BR    = 7'b1100011;

  logic [15:0] c;
  logic [1:0]  quad;
  logic [2:0]  f3;
  logic [4:0]  rd, rs2, rdp, rs1p;
  logic [11:0] wimm, ciimm, sp16, lwsp_off, swsp_off;
  logic [20:0] jimm;
  logic [12:0] bimm;
  logic [31:0] exp_w;
  logic        bad;

  assign c        = in_instr[15:0];
  assign quad     = c[1:0];
  assign f3       = c[15:13];
  assign rd       = c[11:7];
  assign rs2      = c[6:2];
  assign rdp      = {2'b01, c[4:2]};
  assign rs1p     = {2'b01, c[9:7]};
  assign wimm     = {5'b0, c[5], c[12:10], c[6], 2'b00};
  assign ciimm    = {{6{c[12]}}, c[12], c[6:2]};
  assign sp16     = {{2{c[12]}}, c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
  assign lwsp_off = {4'b0, c[3:2], c[12], c[6:4], 2'b00};
  assign swsp_off = {4'b0, c[8:7], c[12:9], 2'b00};
  assign jimm     = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign bimm     = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};

  always_comb begin
    exp_w = 32'h0;
    bad   = 1'b0;
    case (quad)
      2'b00: case (f3)
        3'b010:  exp_w = {wimm, rs1p, 3'b010, rdp, OP_LOAD};
        3'b110:  exp_w = {wimm[11:5], rdp, rs1p, 3'b010, wimm[4:0], OP_STORE};
        default: bad = 1'b1;
      endcase
      2'b01: case (f3)
        3'b000:  exp_w = {ciimm, rd, 3'b000, rd, OP_IMM};
        3'b001:  exp_w = {jimm[20], jimm[10:1], jimm[11], jimm[19:12], 5'd1, OP_JAL};
        3'b010:  exp_w = {ciimm, 5'd0, 3'b000, rd, OP_IMM};
        3'b011: begin
          if (rd == 5'd2 && sp16 != 12'd0)
            exp_w = {sp16, 5'd2, 3'b000, 5'd2, OP_IMM};
          else
            bad = 1'b1;
        end
        3'b101:  exp_w = {jimm[20], jimm[10:1], jimm[11], jimm[19:12], 5'd0, OP_JAL};
        3'b110, 3'b111:
          exp_w = {bimm[12], bimm[10:5], 5'd0, rs1p, 2'b00, f3[0], bimm[4:1], bimm[11], OP_BR};
        default: bad = 1'b1;
      endcase
      2'b10: case (f3)
        3'b010:  exp_w = {lwsp_off, 5'd2, 3'b010, rd, OP_LOAD};
        3'b110:  exp_w = {swsp_off[11:5], rs2, 5'd2, 3'b010, swsp_off[4:0], OP_STORE};
        3'b100: begin
          if (!c[12] && rd != 5'd0 && rs2 != 5'd0)
            exp_w = {7'b0, rs2, 5'd0, 3'b000, rd, OP_REG};
          else if (c[12] && rs2 != 5'd0)
            exp_w = {7'b0, rs2, rd, 3'b000, rd, OP_REG};
          else
            bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
      default: exp_w = in_instr;
    endcase
    if (bad) exp_w = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_instr   <= 32'h0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_instr   <= exp_w;
        out_illegal <= bad;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] == 2'b11) |=> (out_instr == $past(in_instr) && !out_illegal)); // R2
  AST_ZERO_WORD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[15:0] == 16'h0) |=> out_illegal); // R11
  AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_instr == 32'h0); // R11
  AST_LEGAL_IS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> out_instr[1:0] == 2'b11); // R2
  AST_MOVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] == 2'b10 && in_instr[15:12] == 4'b1000 &&
     (in_instr[11:7] == 5'd0 || in_instr[6:2] == 5'd0)) |=> out_illegal); // R10
  AST_SP_ZERO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] == 2'b01 && in_instr[15:13] == 3'b011 &&
     in_instr[12] == 1'b0 && in_instr[6:2] == 5'd0) |=> out_illegal); // R7
endmodule

// File: tb/rvc_expander_tb.sv
module rvc_expander_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = 32'h0;
  logic        out_valid;
  logic [31:0] out_instr;
  logic        out_illegal;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rvc_expander u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
                      .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f);
    return {imm[12], imm[10:5], 5'd0, rs1, f, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs2, logic [4:0] rs1, logic [4:0] rd);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [31:0] w, logic [31:0] exp_w, logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = $urandom;
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " instr"}, out_instr, exp_w);
    check({tag, " illegal"}, {31'b0, out_illegal}, {31'b0, exp_ill});
  endtask

  task automatic rand_form(int k);
    logic [2:0] a = 3'($urandom);
    logic [2:0] b = 3'($urandom);
    logic [4:0] r = 5'($urandom_range(1, 31));
    logic [4:0] s = 5'($urandom_range(1, 31));
    logic [5:0] i6 = 6'($urandom);
    logic [7:0] o8 = 8'($urandom);
    logic [11:0] o12 = {11'($urandom), 1'b0};
    logic [8:0] o9 = {8'($urandom), 1'b0};
    logic [6:0] w7 = {5'($urandom), 2'b00};
    logic [11:0] se6 = {{6{i6[5]}}, i6};
    case (k)
      0: apply("R4 R3 lw", {16'h0, 3'b010, w7[5:3], a, w7[2], w7[6], b, 2'b00},
               enc_i({5'b0, w7}, {2'b01, a}, 3'b010, {2'b01, b}, 7'b0000011), 1'b0);
      1: apply("R4 R3 sw", {16'h0, 3'b110, w7[5:3], a, w7[2], w7[6], b, 2'b00},
               enc_s({5'b0, w7}, {2'b01, b}, {2'b01, a}), 1'b0);
      2: apply("R6 addi", {16'h0, 3'b000, i6[5], r, i6[4:0], 2'b01},
               enc_i(se6, r, 3'b000, r, 7'b0010011), 1'b0);
      3: apply("R6 li", {16'h0, 3'b010, i6[5], r, i6[4:0], 2'b01},
               enc_i(se6, 5'd0, 3'b000, r, 7'b0010011), 1'b0);
      4: apply("R8 jal", {16'h0, 3'b001, o12[11], o12[4], o12[9:8], o12[10], o12[6], o12[7], o12[3:1], o12[5], 2'b01},
               enc_j({{9{o12[11]}}, o12}, 5'd1), 1'b0);
      5: apply("R8 j", {16'h0, 3'b101, o12[11], o12[4], o12[9:8], o12[10], o12[6], o12[7], o12[3:1], o12[5], 2'b01},
               enc_j({{9{o12[11]}}, o12}, 5'd0), 1'b0);
      6: begin
        logic [5:0] n = 6'($urandom_range(1, 63));
        logic [9:0] m = {n, 4'b0};
        apply("R7 addi16sp", {16'h0, 3'b011, m[9], 5'd2, m[4], m[6], m[8:7], m[5], 2'b01},
              enc_i({{2{m[9]}}, m}, 5'd2, 3'b000, 5'd2, 7'b0010011), 1'b0);
      end
      7: apply("R9 R3 beqz", {16'h0, 3'b110, o9[8], o9[4:3], a, o9[7:6], o9[2:1], o9[5], 2'b01},
               enc_b({{4{o9[8]}}, o9}, {2'b01, a}, 3'b000), 1'b0);
      8: apply("R9 R3 bnez", {16'h0, 3'b111, o9[8], o9[4:3], a, o9[7:6], o9[2:1], o9[5], 2'b01},
               enc_b({{4{o9[8]}}, o9}, {2'b01, a}, 3'b001), 1'b0);
      9: apply("R5 lwsp", {16'h0, 3'b010, o8[5], r, o8[4:2], o8[7:6], 2'b10},
               enc_i({4'b0, o8[7:2], 2'b00}, 5'd2, 3'b010, r, 7'b0000011), 1'b0);
      10: apply("R5 swsp", {16'h0, 3'b110, o8[5:2], o8[7:6], s, 2'b10},
                enc_s({4'b0, o8[7:2], 2'b00}, s, 5'd2), 1'b0);
      11: apply("R10 mv", {16'h0, 4'b1000, r, s, 2'b10}, enc_r(s, 5'd0, r), 1'b0);
      12: apply("R10 add", {16'h0, 4'b1001, r, s, 2'b10}, enc_r(s, r, r), 1'b0);
      default: begin
        logic [31:0] w = {$urandom, 2'b11} >> 0;
        w[1:0] = 2'b11;
        apply("R2 pass", w, w, 1'b0);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset instr", out_instr, 32'd0);
    check("R1 reset illegal", {31'b0, out_illegal}, 32'd0);
    rst_n = 1'b1;
    void'($urandom(32'd1234));
    apply("R11 zero", 32'h0, 32'h0, 1'b1);
    apply("R2 pass fixed", 32'h00A50533, 32'h00A50533, 1'b0);
    apply("R10 mv rd0", {16'h0, 4'b1000, 5'd0, 5'd7, 2'b10}, 32'h0, 1'b1);
    apply("R10 mv rs0", {16'h0, 4'b1000, 5'd7, 5'd0, 2'b10}, 32'h0, 1'b1);
    apply("R10 add rs0", {16'h0, 4'b1001, 5'd7, 5'd0, 2'b10}, 32'h0, 1'b1);
    apply("R7 zero imm", {16'h0, 3'b011, 1'b0, 5'd2, 5'd0, 2'b01}, 32'h0, 1'b1);
    apply("R11 lui form", {16'h0, 3'b011, 1'b0, 5'd5, 5'd1, 2'b01}, 32'h0, 1'b1);
    apply("R11 q0 f000", 32'h00000004, 32'h0, 1'b1);
    apply("R11 q2 f000", {16'h0, 3'b000, 1'b0, 5'd3, 5'd1, 2'b10}, 32'h0, 1'b1);
    apply("R6 addi min", {16'h0, 3'b000, 1'b1, 5'd9, 5'd0, 2'b01},
          enc_i(12'hFE0, 5'd9, 3'b000, 5'd9, 7'b0010011), 1'b0);
    apply("R8 j neg", {16'h0, 3'b101, 11'h7FF, 2'b01}, enc_j(21'h1FFFFE, 5'd0), 1'b0);
    @(negedge clk);
    check("R1 idle valid", {31'b0, out_valid}, 32'd0);
    for (int n = 0; n < 600; n++) rand_form(int'($urandom_range(0, 13)));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (20000) @(posedge clk);
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule